// File: doc/BRIEF.md
# Standby Power Domain Sequencer

This controller moves a set of switchable power domains (three by default, indexed 0 upward) between an active state and a retention state as the device goes into and comes out of standby. An always-on domain that hosts the controller itself is never switched. Peripherals that must keep working during standby raise a per-domain keep-active request. Each such request holds its own domain and every lower-indexed domain active, so the domains that get retained always form a contiguous run at the top of the index range.

When a sleep request arrives while the CPU runs, the sequencer captures the keep-active pattern. It then retains the selected domains one at a time, highest index first, and finishes each request/acknowledge handshake before it starts the next. Only when every switchable domain has been retained does it move the core supply onto the low-power regulator. A wake interrupt restores the retained domains one at a time in ascending order. If the low-power regulator was in use, the sequencer also waits for the main regulator to report ready before the CPU may run again. A wake interrupt that arrives partway through entry aborts the entry and restores whatever has already been retained.

Top module: `pd_standby_seq`

## Requirements
- R1: After reset no domain is requested into retention, every status bit reads active (0), the low-power regulator select is 0, cpu_run is 1 and busy is 0.
- R2: A sleep_req seen while cpu_run is 1 captures keep_act, where bit i keeps domain i active. The domains then retained are exactly those whose index is above the highest set keep bit, or all domains when keep_act is 0.
- R3: On entry, retention requests (dom_ret_req bit i = 1) are raised in descending index order. A request is raised only after the previous domain's acknowledge is high.
- R4: On wake from standby, retention requests are dropped in ascending index order. The next domain is handled only after the previous domain's acknowledge has returned to 0.
- R5: lp_reg_sel rises only once all domains are retained and acknowledged, and it stays 0 whenever any domain is kept active.
- R6: A wake after low-power entry drops lp_reg_sel as restore begins. cpu_run then stays 0 after all domains are restored until main_reg_rdy is 1.
- R7: When any domain was kept active, wake-up completes and cpu_run returns to 1 with main_reg_rdy held at 0.
- R8: A wake_irq during entry abandons the entry. Retention requests already raised are dropped in ascending order, lp_reg_sel never rises, and cpu_run returns to 1.
- R9: Each dom_retained bit equals that domain's acknowledge as it was one clock earlier.
- R10: busy is 1 during entry, restore and regulator wait, and 0 in run and in standby. cpu_run is 1 only in run and never together with busy.
- R11: Changes on keep_act after entry has begun do not alter the retained set, and a wake_irq while the CPU runs starts no sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req | input | 1 | Request to enter standby, sampled while running |
| keep_act | input | NUM_DOM | Per-domain keep-active request, bit i for domain i |
| wake_irq | input | 1 | Wake interrupt from the always-on domain |
| dom_ret_req | output | NUM_DOM | Per-domain request: 1 = retention, 0 = active |
| dom_ret_ack | input | NUM_DOM | Per-domain acknowledge: 1 = domain is in retention |
| lp_reg_sel | output | 1 | 1 selects the low-power core regulator |
| main_reg_rdy | input | 1 | Main regulator reports stable output |
| cpu_run | output | 1 | CPU is allowed to execute |
| dom_retained | output | NUM_DOM | Status per domain: 1 = retention, 0 = active |
| busy | output | 1 | A sequence is in progress |

## Verification
On every cycle the assertions check the handshake ordering between neighbouring domains in both directions, that the low-power regulator is selected only with all domains retained, that the CPU stays halted while a required main-regulator ready is missing, that run and busy are exclusive, and that status follows the acknowledges. What only the bench scenarios can show is that the right domain set is retained for every one of the eight keep patterns, that the full event order of each entry and exit matches the computed list, that an aborted entry unwinds correctly, and that late changes on keep_act and stray wake pulses have no effect.

// File: rtl/pds_pkg.sv
package pds_pkg;
  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_ENTER = 3'd1,
    ST_STBY  = 3'd2,
    ST_EXIT  = 3'd3,
    ST_WREG  = 3'd4
  } seq_state_t;
endpackage

// File: rtl/pds_retain_plan.sv
module pds_retain_plan #(
  parameter int NUM_DOM = 3
) (
  input  logic [NUM_DOM-1:0] keep,
  output logic [NUM_DOM-1:0] plan
);
  // A domain may be retained only if neither it nor any higher domain is kept.
  for (genvar g = 0; g < NUM_DOM; g++) begin : g_plan
    assign plan[g] = ~(|keep[NUM_DOM-1:g]);
  end
endmodule

// File: rtl/pds_dom_chan.sv
module pds_dom_chan (
  input  logic clk,
  input  logic rst,
  input  logic set_ret,
  input  logic clr_ret,
  input  logic ack,
  output logic req,
  output logic ret_stat
);
  always_ff @(posedge clk) begin
    if (rst) begin
      req      <= 1'b0;
      ret_stat <= 1'b0;
    end else begin
      if (set_ret)      req <= 1'b1;
      else if (clr_ret) req <= 1'b0;
      ret_stat <= ack;
    end
  end

  // R9: status mirrors the acknowledge one clock later
  assert_stat_follow_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (ret_stat == $past(ack)));
endmodule

// File: rtl/pd_standby_seq.sv
module pd_standby_seq #(
  parameter int NUM_DOM = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sleep_req,
  input  logic [NUM_DOM-1:0] keep_act,
  input  logic               wake_irq,
  output logic [NUM_DOM-1:0] dom_ret_req,
  input  logic [NUM_DOM-1:0] dom_ret_ack,
  output logic               lp_reg_sel,
  input  logic               main_reg_rdy,
  output logic               cpu_run,
  output logic [NUM_DOM-1:0] dom_retained,
  output logic               busy
);
  import pds_pkg::*;

  localparam int CW = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1;
  localparam logic [CW-1:0] LAST = CW'(NUM_DOM - 1);

  seq_state_t        state;
  logic [CW-1:0]     cur;
  logic [NUM_DOM-1:0] plan, plan_q;
  logic [NUM_DOM-1:0] set_vec, clr_vec;
  logic               used_lp;

  pds_retain_plan #(.NUM_DOM(NUM_DOM)) u_plan (
    .keep (keep_act),
    .plan (plan)
  );

  for (genvar g = 0; g < NUM_DOM; g++) begin : g_chan
    pds_dom_chan u_chan (
      .clk      (clk),
      .rst      (rst),
      .set_ret  (set_vec[g]),
      .clr_ret  (clr_vec[g]),
      .ack      (dom_ret_ack[g]),
      .req      (dom_ret_req[g]),
      .ret_stat (dom_retained[g])
    );
  end

  always_comb begin
    set_vec = '0;
    clr_vec = '0;
    if (state == ST_ENTER && !wake_irq && plan_q[cur] && !dom_ret_req[cur])
      set_vec[cur] = 1'b1;
    if (state == ST_EXIT && dom_ret_req[cur])
      clr_vec[cur] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_RUN;
      cur        <= '0;
      plan_q     <= '0;
      lp_reg_sel <= 1'b0;
      used_lp    <= 1'b0;
    end else begin
      case (state)
        ST_RUN: begin
          if (sleep_req) begin
            plan_q  <= plan;
            cur     <= LAST;
            used_lp <= 1'b0;
            state   <= ST_ENTER;
          end
        end
        ST_ENTER: begin
          if (wake_irq) begin
            cur   <= '0;
            state <= ST_EXIT;
          end else if (!plan_q[cur]) begin
            state <= ST_STBY;
          end else if (dom_ret_req[cur] && dom_ret_ack[cur]) begin
            if (cur == '0) begin
              lp_reg_sel <= 1'b1;
              state      <= ST_STBY;
            end else begin
              cur <= cur - 1'b1;
            end
          end
        end
        ST_STBY: begin
          if (wake_irq) begin
            used_lp    <= lp_reg_sel;
            lp_reg_sel <= 1'b0;
            cur        <= '0;
            state      <= ST_EXIT;
          end
        end
        ST_EXIT: begin
          if (!dom_ret_req[cur] && !dom_ret_ack[cur]) begin
            if (cur == LAST) state <= ST_WREG;
            else             cur   <= cur + 1'b1;
          end
        end
        ST_WREG: begin
          if (!used_lp || main_reg_rdy) state <= ST_RUN;
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  assign cpu_run = (state == ST_RUN);
  assign busy    = (state == ST_ENTER) || (state == ST_EXIT) || (state == ST_WREG);

  // Ordering between neighbouring domains
  for (genvar g = 0; g < NUM_DOM - 1; g++) begin : g_ord
    // R3: a lower domain is retained only once the one above is acknowledged
    assert_enter_desc_R3: assert property (@(posedge clk) disable iff (rst)
      set_vec[g] |-> (dom_ret_req[g+1] && dom_ret_ack[g+1]));
    // R4: a higher domain is restored only once the one below is back
    assert_exit_asc_R4: assert property (@(posedge clk) disable iff (rst)
      clr_vec[g+1] |-> (!dom_ret_req[g] && !dom_ret_ack[g]));
  end

  // R5: low-power regulator only with every domain retained
  assert_lp_all_ret_R5: assert property (@(posedge clk) disable iff (rst)
    lp_reg_sel |-> (&dom_ret_req));

  // R6: no CPU start while a needed main regulator is not ready
  assert_wait_reg_R6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WREG && used_lp && !main_reg_rdy) |=> !cpu_run);

  // R10: running and sequencing are exclusive
  assert_run_excl_R10: assert property (@(posedge clk) disable iff (rst)
    !(cpu_run && busy));

  // R1: while the CPU runs nothing is retained and the main regulator is selected
  assert_run_clean_R1: assert property (@(posedge clk) disable iff (rst)
    cpu_run |-> (dom_ret_req == '0 && !lp_reg_sel));
endmodule

// File: tb/test_pd_standby_seq.sv
module test_pd_standby_seq;
  localparam int N = 3;
  localparam int ACK_DLY = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sleep_req = 1'b0;
  logic [N-1:0] keep_act = '0;
  logic wake_irq = 1'b0;
  logic [N-1:0] dom_ret_req;
  logic [N-1:0] dom_ret_ack;
  logic lp_reg_sel;
  logic main_reg_rdy = 1'b0;
  logic cpu_run;
  logic [N-1:0] dom_retained;
  logic busy;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  pd_standby_seq #(.NUM_DOM(N)) i_pd_standby_seq (
    .clk(clk), .rst(rst), .sleep_req(sleep_req), .keep_act(keep_act),
    .wake_irq(wake_irq), .dom_ret_req(dom_ret_req), .dom_ret_ack(dom_ret_ack),
    .lp_reg_sel(lp_reg_sel), .main_reg_rdy(main_reg_rdy), .cpu_run(cpu_run),
    .dom_retained(dom_retained), .busy(busy)
  );

  // Domain model: acknowledge follows request after ACK_DLY clocks
  logic [ACK_DLY-1:0] pipe [N];
  always @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (rst) pipe[i] <= '0;
      else     pipe[i] <= {pipe[i][ACK_DLY-2:0], dom_ret_req[i]};
    end
  end
  always_comb for (int i = 0; i < N; i++) dom_ret_ack[i] = pipe[i][ACK_DLY-1];

  // Monitor: event log, handshake rule, status lag, low-power seen
  int ev_n = 0;
  int ev_idx [32];
  int ev_val [32];
  int hs_viol = 0;
  int st_viol = 0;
  bit lp_seen = 1'b0;
  logic [N-1:0] prev_req = '0;
  logic [N-1:0] prev_ack = '0;
  logic [N-1:0] prev_req_q = '0;
  bit mon_on = 1'b0;
  always @(negedge clk) begin
    if (mon_on) begin
      if (lp_reg_sel) lp_seen = 1'b1;
      if (dom_retained != prev_ack) st_viol++;
      for (int j = 0; j < N; j++) begin
        if (dom_ret_req[j] != prev_req[j]) begin
          if (ev_n < 32) begin
            ev_idx[ev_n] = j;
            ev_val[ev_n] = int'(dom_ret_req[j]);
          end
          ev_n++;
          for (int m = 0; m < N; m++)
            if (m != j && prev_req_q[m] != prev_ack[m]) hs_viol++;
        end
      end
    end
    prev_req   = dom_ret_req;
    prev_req_q = dom_ret_req;
    prev_ack   = dom_ret_ack;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_until_idle(output bit ok);
    ok = 1'b0;
    for (int c = 0; c < 300; c++) begin
      @(negedge clk);
      if (!busy) begin ok = 1'b1; break; end
    end
  endtask

  task automatic wait_run(output bit ok);
    ok = 1'b0;
    for (int c = 0; c < 300; c++) begin
      @(negedge clk);
      if (cpu_run) begin ok = 1'b1; break; end
    end
  endtask

  task automatic pulse_sleep();
    @(negedge clk) sleep_req = 1'b1;
    @(negedge clk) sleep_req = 1'b0;
  endtask

  task automatic pulse_wake();
    wake_irq = 1'b1;
    @(negedge clk) wake_irq = 1'b0;
  endtask

  // Full standby cycle for one keep pattern
  task automatic run_cycle(input logic [N-1:0] keep);
    int h;
    logic [N-1:0] exp_plan;
    int cnt;
    bit ok;
    bit seq_ok;
    h = -1;
    for (int i = 0; i < N; i++) if (keep[i]) h = i;
    exp_plan = '0;
    for (int i = 0; i < N; i++) if (i > h) exp_plan[i] = 1'b1;
    cnt = N - 1 - h;
    ev_n = 0; lp_seen = 1'b0; main_reg_rdy = 1'b0;
    keep_act = keep;
    @(negedge clk) sleep_req = 1'b1;
    @(negedge clk) sleep_req = 1'b0;
    keep_act = ~keep; // R11: late change must be ignored
    wait_until_idle(ok);
    chk(ok && !cpu_run, "R10 standby reached, cpu halted", int'(cpu_run), 0);
    chk(dom_ret_req == exp_plan, "R2 retained set", int'(dom_ret_req), int'(exp_plan));
    chk(dom_retained == exp_plan, "R9 status in standby", int'(dom_retained), int'(exp_plan));
    chk(lp_reg_sel == (exp_plan == '1), "R5 regulator select", int'(lp_reg_sel), int'(exp_plan == '1));
    repeat (5) @(negedge clk);
    chk(!busy && dom_ret_req == exp_plan, "R11 standby stable after keep change",
        int'(dom_ret_req), int'(exp_plan));
    pulse_wake();
    if (exp_plan == '1) begin
      chk(!lp_reg_sel, "R6 regulator back to main on wake", int'(lp_reg_sel), 0);
      ok = 1'b0;
      for (int c = 0; c < 300; c++) begin
        @(negedge clk);
        if (dom_ret_req == '0 && dom_ret_ack == '0) begin ok = 1'b1; break; end
      end
      repeat (4) @(negedge clk);
      chk(ok && !cpu_run && busy, "R6 cpu held until main ready", int'(cpu_run), 0);
      main_reg_rdy = 1'b1;
      repeat (3) @(negedge clk);
      chk(cpu_run && !busy, "R6 cpu released after main ready", int'(cpu_run), 1);
    end else begin
      wait_run(ok);
      chk(ok, "R7 wake without main ready", int'(cpu_run), 1);
      chk(!lp_seen, "R5 no low-power with kept domain", int'(lp_seen), 0);
    end
    // Event order: entry descending, exit ascending
    seq_ok = (ev_n == 2 * cnt);
    for (int k = 0; k < cnt && seq_ok; k++)
      if (ev_idx[k] != N - 1 - k || ev_val[k] != 1) seq_ok = 1'b0;
    chk(seq_ok, "R3 entry order", ev_n, 2 * cnt);
    seq_ok = (ev_n == 2 * cnt);
    for (int k = 0; k < cnt && seq_ok; k++)
      if (ev_idx[cnt + k] != h + 1 + k || ev_val[cnt + k] != 0) seq_ok = 1'b0;
    chk(seq_ok, "R4 exit order", ev_n, 2 * cnt);
    main_reg_rdy = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    bit ok;
    bit seq_ok;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    mon_on = 1'b1;
    chk(cpu_run && !busy && !lp_reg_sel && dom_ret_req == '0 && dom_retained == '0,
        "R1 reset state", int'({cpu_run, busy, lp_reg_sel}), 4);

    // R11: wake while running does nothing
    wake_irq = 1'b1;
    @(negedge clk) wake_irq = 1'b0;
    repeat (3) @(negedge clk);
    chk(cpu_run && !busy && dom_ret_req == '0, "R11 wake while running ignored",
        int'(dom_ret_req), 0);

    // Sweep every keep pattern
    for (int k = 0; k < (1 << N); k++) run_cycle(N'(k));

    // R8: wake during entry
    ev_n = 0; lp_seen = 1'b0; main_reg_rdy = 1'b0; keep_act = '0;
    pulse_sleep();
    ok = 1'b0;
    for (int c = 0; c < 100; c++) begin
      if (dom_ret_req[1]) begin ok = 1'b1; break; end
      @(negedge clk);
    end
    pulse_wake();
    wait_run(ok);
    chk(ok && !lp_seen, "R8 abort returns to run without low-power", int'(lp_seen), 0);
    seq_ok = (ev_n == 4) && ev_idx[0] == 2 && ev_val[0] == 1 && ev_idx[1] == 1 && ev_val[1] == 1
             && ev_idx[2] == 1 && ev_val[2] == 0 && ev_idx[3] == 2 && ev_val[3] == 0;
    chk(seq_ok, "R8 abort unwind order", ev_n, 4);
    repeat (4) @(negedge clk);

    chk(hs_viol == 0, "R3 handshake completes before next domain", hs_viol, 0);
    chk(st_viol == 0, "R9 status lags acknowledge by one clock", st_viol, 0);

    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule